// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a cellular-style keystream from three linear feedback shift registers of 19, 22 and 23 bits, 64 state bits in all. A start pulse captures a 64-bit session key and a 22-bit frame number. The block then clears its registers and loads the key followed by the frame number, one bit per cycle. It runs a silent warm-up under irregular majority clocking and then streams a 114-bit keystream frame at one bit per cycle.

After each frame the block adds one to the frame number. It reloads the same session key and produces the next frame, and it keeps doing so until reset. A build-time parameter chooses how the three register outputs are combined into the keystream bit. The choices are a plain three-input XOR or a 4-to-1 multiplexer steered by two of the registers.

Top module: `kg_keystream`

## Requirements
- R1: While reset is held, and after it is released with no start, `ks_valid_o`, `ks_bit_o` and `frame_done_o` are all low.
- R2: A start pulse seen in the idle state captures `key_i` and `fn_i`. The first valid keystream bit appears 186 clock edges after the edge that sampled start (64 key cycles + 22 frame cycles + 100 warm-up cycles).
- R3: During loading every register shifts on every cycle, regardless of majority. The key enters least significant bit first and is followed by the frame number, also least significant bit first. Each incoming bit is XORed with the register's feedback before it enters bit 0.
- R4: Register feedback taps are bits {18,17,16,13}, {21,20} and {22,21,20,7}. In warm-up and output the clocking bits are bit 8, bit 10 and bit 10. A register shifts only when its clocking bit equals the majority of the three, so at least two registers shift each cycle.
- R5: With the XOR combiner, each keystream bit is the XOR of bit 18, bit 21 and bit 22 of the three registers, taken before that cycle's shift.
- R6: With the multiplexer combiner, the select is {register 1 bit 18, register 2 bit 21}. Select 0 passes register 3 bit 22, select 1 passes its inverse, select 2 passes register 3 bit 0 and select 3 passes register 3 bit 11.
- R7: A frame is exactly 114 consecutive cycles of `ks_valid_o`. `frame_done_o` is high only with the 114th bit, and `ks_valid_o` is low in the cycle after it.
- R8: After each frame the frame number increments by one, modulo 2^22. The next frame loads the captured key and the new number, and its first bit comes 187 cycles after the `frame_done_o` cycle.
- R9: Start pulses and changes on `key_i` or `fn_i` while a sequence is running have no effect on the keystream.
- R10: `ks_bit_o` is low whenever `ks_valid_o` is low.
- R11: All three registers are cleared to zero before every load sequence, so each frame depends only on the key and its frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a keystream run; sampled only when idle |
| key_i | input | 64 | Session key |
| fn_i | input | 22 | Initial frame number |
| ks_bit_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |
| frame_done_o | output | 1 | Marks the last bit of a frame |

## Verification
Any slip in a tap, a clocking bit, the load order or the majority rule corrupts the register state. That error reaches the keystream no later than the first valid bit, 186 cycles after start, and is then visible as a mismatch against an independent bit-level model. A sequencer miscount shows as a wrong latency, a frame longer or shorter than 114 bits, or a misplaced done flag. A bad frame-number increment or a missed register clear stays hidden until the second frame, so every scenario compares two consecutive frames for both combiner variants.

// File: rtl/kg_pkg.sv
package kg_pkg;

    localparam int KG_R1_LEN = 19;
    localparam int KG_R2_LEN = 22;
    localparam int KG_R3_LEN = 23;

    localparam logic [KG_R1_LEN-1:0] KG_R1_TAPS = 19'h72000;
    localparam logic [KG_R2_LEN-1:0] KG_R2_TAPS = 22'h300000;
    localparam logic [KG_R3_LEN-1:0] KG_R3_TAPS = 23'h700080;

    localparam int KG_R1_CLK = 8;
    localparam int KG_R2_CLK = 10;
    localparam int KG_R3_CLK = 10;

    localparam int KG_MUX_LO_TAP = 0;
    localparam int KG_MUX_HI_TAP = 11;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_KEY,
        PH_FN,
        PH_WARM,
        PH_OUT
    } phase_t;

    typedef struct packed {
        logic clr;
        logic force_shift;
        logic din;
        logic maj_en;
    } lfsr_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    function automatic logic mux4(input logic [1:0] sel, input logic d0,
                                  input logic d1, input logic d2, input logic d3);
        logic y;
        case (sel)
            2'd0:    y = d0;
            2'd1:    y = d1;
            2'd2:    y = d2;
            default: y = d3;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/kg_lfsr.sv
module kg_lfsr
    import kg_pkg::*;
#(
    parameter int             LEN  = 19,
    parameter logic [LEN-1:0] TAPS = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           shift,
    input  logic           din,
    output logic [LEN-1:0] state_o
);

    logic [LEN-1:0] state_q;
    logic           fb;

    always_comb begin
        fb = ^(state_q & TAPS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (clr) begin
            state_q <= '0;
        end else if (shift) begin
            state_q <= {state_q[LEN-2:0], fb ^ din};
        end
    end

    assign state_o = state_q;

    // R4: a register that is not stepped keeps its contents
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!shift && !clr) |=> $stable(state_q));

endmodule

// File: rtl/kg_sequencer.sv
module kg_sequencer
    import kg_pkg::*;
#(
    parameter int KEY_W      = 64,
    parameter int FN_W       = 22,
    parameter int WARM_CYC   = 100,
    parameter int FRAME_BITS = 114
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [KEY_W-1:0] key_i,
    input  logic [FN_W-1:0]  fn_i,
    output lfsr_ctl_t        ctl_o,
    output logic             valid_o,
    output logic             done_o
);

    localparam int MAX_CNT = max2(max2(KEY_W, FN_W), max2(WARM_CYC, FRAME_BITS));
    localparam int CNT_W   = $clog2(MAX_CNT);

    phase_t             phase_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [KEY_W-1:0]   key_q;
    logic [KEY_W-1:0]   key_sh;
    logic [FN_W-1:0]    fn_q;
    logic [FN_W-1:0]    fn_sh;
    logic               last;
    logic               accept;

    always_comb begin
        case (phase_q)
            PH_KEY:  last = (cnt_q == CNT_W'(KEY_W - 1));
            PH_FN:   last = (cnt_q == CNT_W'(FN_W - 1));
            PH_WARM: last = (cnt_q == CNT_W'(WARM_CYC - 1));
            PH_OUT:  last = (cnt_q == CNT_W'(FRAME_BITS - 1));
            default: last = 1'b0;
        endcase
        accept = (phase_q == PH_IDLE) && start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            key_q   <= '0;
            key_sh  <= '0;
            fn_q    <= '0;
            fn_sh   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        phase_q <= PH_KEY;
                        cnt_q   <= '0;
                        key_q   <= key_i;
                        key_sh  <= key_i;
                        fn_q    <= fn_i;
                        fn_sh   <= fn_i;
                    end
                end
                PH_KEY: begin
                    key_sh <= key_sh >> 1;
                    if (last) begin
                        phase_q <= PH_FN;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FN: begin
                    fn_sh <= fn_sh >> 1;
                    if (last) begin
                        phase_q <= PH_WARM;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_WARM: begin
                    if (last) begin
                        phase_q <= PH_OUT;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_OUT: begin
                    if (last) begin
                        phase_q <= PH_KEY;
                        cnt_q   <= '0;
                        fn_q    <= fn_q + 1'b1;
                        fn_sh   <= fn_q + 1'b1;
                        key_sh  <= key_q;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        ctl_o.clr         = accept || ((phase_q == PH_OUT) && last);
        ctl_o.force_shift = (phase_q == PH_KEY) || (phase_q == PH_FN);
        ctl_o.maj_en      = (phase_q == PH_WARM) || (phase_q == PH_OUT);
        if (phase_q == PH_KEY)
            ctl_o.din = key_sh[0];
        else if (phase_q == PH_FN)
            ctl_o.din = fn_sh[0];
        else
            ctl_o.din = 1'b0;
        valid_o = (phase_q == PH_OUT);
        done_o  = (phase_q == PH_OUT) && last;
    end

    // R7: the frame ends and output stops right after the done flag
    assert_frame_end_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !valid_o);

    // R7: every frame begins at the first bit position
    assert_frame_begin_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> (cnt_q == '0));

    // R8: frame number steps by one at each frame boundary
    assert_fn_step_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (fn_q == $past(fn_q) + 1'b1));

    // R9: a running sequence does not recapture the frame number
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ((phase_q != PH_IDLE) && !done_o) |=> $stable(fn_q) && $stable(key_q));

endmodule

// File: rtl/kg_combiner.sv
module kg_combiner
    import kg_pkg::*;
#(
    parameter int LEN3    = 23,
    parameter bit USE_MUX = 1'b0
) (
    input  logic            m1,
    input  logic            m2,
    input  logic [LEN3-1:0] r3,
    output logic            y
);

    logic xor_v;
    logic mux_v;

    always_comb begin
        xor_v = m1 ^ m2 ^ r3[LEN3-1];
        mux_v = mux4({m1, m2}, r3[LEN3-1], ~r3[LEN3-1],
                     r3[KG_MUX_LO_TAP], r3[KG_MUX_HI_TAP]);
        y     = USE_MUX ? mux_v : xor_v;
    end

endmodule

// File: rtl/kg_keystream.sv
module kg_keystream
    import kg_pkg::*;
#(
    parameter int KEY_W      = 64,
    parameter int FN_W       = 22,
    parameter int WARM_CYC   = 100,
    parameter int FRAME_BITS = 114,
    parameter bit USE_MUX    = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [KEY_W-1:0] key_i,
    input  logic [FN_W-1:0]  fn_i,
    output logic             ks_bit_o,
    output logic             ks_valid_o,
    output logic             frame_done_o
);

    lfsr_ctl_t              ctl;
    logic                   valid;
    logic                   done;
    logic [KG_R1_LEN-1:0]   r1;
    logic [KG_R2_LEN-1:0]   r2;
    logic [KG_R3_LEN-1:0]   r3;
    logic [2:0]             cb;
    logic                   maj;
    logic [2:0]             step;
    logic                   comb_bit;

    kg_sequencer #(
        .KEY_W     (KEY_W),
        .FN_W      (FN_W),
        .WARM_CYC  (WARM_CYC),
        .FRAME_BITS(FRAME_BITS)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .key_i  (key_i),
        .fn_i   (fn_i),
        .ctl_o  (ctl),
        .valid_o(valid),
        .done_o (done)
    );

    always_comb begin
        cb   = {r3[KG_R3_CLK], r2[KG_R2_CLK], r1[KG_R1_CLK]};
        maj  = maj3(cb[0], cb[1], cb[2]);
        for (int i = 0; i < 3; i++) begin
            step[i] = ctl.force_shift || (ctl.maj_en && (cb[i] == maj));
        end
    end

    kg_lfsr #(.LEN(KG_R1_LEN), .TAPS(KG_R1_TAPS)) u_r1 (
        .clk(clk), .rst(rst), .clr(ctl.clr), .shift(step[0]),
        .din(ctl.din), .state_o(r1)
    );

    kg_lfsr #(.LEN(KG_R2_LEN), .TAPS(KG_R2_TAPS)) u_r2 (
        .clk(clk), .rst(rst), .clr(ctl.clr), .shift(step[1]),
        .din(ctl.din), .state_o(r2)
    );

    kg_lfsr #(.LEN(KG_R3_LEN), .TAPS(KG_R3_TAPS)) u_r3 (
        .clk(clk), .rst(rst), .clr(ctl.clr), .shift(step[2]),
        .din(ctl.din), .state_o(r3)
    );

    kg_combiner #(.LEN3(KG_R3_LEN), .USE_MUX(USE_MUX)) u_comb (
        .m1(r1[KG_R1_LEN-1]),
        .m2(r2[KG_R2_LEN-1]),
        .r3(r3),
        .y (comb_bit)
    );

    assign ks_valid_o   = valid;
    assign ks_bit_o     = valid & comb_bit;
    assign frame_done_o = done;

    // R4: under majority clocking at least two registers advance
    assert_majority_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl.maj_en && !ctl.clr) |-> ($countones(step) >= 2));

    // R3: loading never overlaps majority clocking
    assert_load_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(ctl.force_shift && valid));

    // R10: no keystream bit outside a frame
    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !ks_valid_o |-> !ks_bit_o);

endmodule

// File: tb/kg_keystream_tb.sv
module kg_keystream_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NBITS      = 114;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] key_i = '0;
    logic [21:0] fn_i = '0;
    logic        bit_x, val_x, done_x;
    logic        bit_m, val_m, done_m;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kg_keystream #(.USE_MUX(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start(start), .key_i(key_i), .fn_i(fn_i),
        .ks_bit_o(bit_x), .ks_valid_o(val_x), .frame_done_o(done_x)
    );

    kg_keystream #(.USE_MUX(1'b1)) u_dut_mux (
        .clk(clk), .rst(rst), .start(start), .key_i(key_i), .fn_i(fn_i),
        .ks_bit_o(bit_m), .ks_valid_o(val_m), .frame_done_o(done_m)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // independent bit-level reference of the generator
    task automatic model(input logic [63:0] k, input logic [21:0] f,
                         input bit use_mux, output logic [NBITS-1:0] ks);
        logic [18:0] a;
        logic [21:0] b;
        logic [22:0] c;
        logic fa, fb, fc, m, sa, sb, sc;
        a = '0; b = '0; c = '0; ks = '0;
        for (int i = 0; i < 86; i++) begin
            logic d;
            d  = (i < 64) ? k[i] : f[i-64];
            fa = a[18] ^ a[17] ^ a[16] ^ a[13];
            fb = b[21] ^ b[20];
            fc = c[22] ^ c[21] ^ c[20] ^ c[7];
            a = {a[17:0], fa ^ d};
            b = {b[20:0], fb ^ d};
            c = {c[21:0], fc ^ d};
        end
        for (int i = 0; i < 100 + NBITS; i++) begin
            if (i >= 100) begin
                if (!use_mux)
                    ks[i-100] = a[18] ^ b[21] ^ c[22];
                else begin
                    case ({a[18], b[21]})
                        2'b00: ks[i-100] = c[22];
                        2'b01: ks[i-100] = ~c[22];
                        2'b10: ks[i-100] = c[0];
                        default: ks[i-100] = c[11];
                    endcase
                end
            end
            m  = (a[8] & b[10]) | (a[8] & c[10]) | (b[10] & c[10]);
            sa = (a[8] == m); sb = (b[10] == m); sc = (c[10] == m);
            fa = a[18] ^ a[17] ^ a[16] ^ a[13];
            fb = b[21] ^ b[20];
            fc = c[22] ^ c[21] ^ c[20] ^ c[7];
            if (sa) a = {a[17:0], fa};
            if (sb) b = {b[20:0], fb};
            if (sc) c = {c[21:0], fc};
        end
    endtask

    // waits for a frame and records it; called at a negedge, returns at the negedge of the last bit
    task automatic grab(output logic [NBITS-1:0] bx, output logic [NBITS-1:0] bm,
                        output int lat, output int done_err);
        lat = 0; done_err = 0; bx = '0; bm = '0;
        while (!val_x && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        for (int i = 0; i < NBITS; i++) begin
            if (i > 0) @(negedge clk);
            bx[i] = bit_x;
            bm[i] = bit_m;
            if (!val_x || !val_m) done_err++;
            if (done_x != (i == NBITS-1) || done_m != (i == NBITS-1)) done_err++;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(!val_x && !val_m, "R1", "valid in reset", {val_x, val_m}, 0);
        chk(!done_x && !done_m, "R1", "done in reset", {done_x, done_m}, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk(!val_x && !val_m && !done_x, "R1", "idle outputs", {val_x, val_m, done_x}, 0);
        chk(!bit_x && !bit_m, "R10", "bit while idle", {bit_x, bit_m}, 0);
    endtask

    task automatic t_frames(input logic [63:0] k, input logic [21:0] f,
                            input bit poke, input string tag);
        logic [NBITS-1:0] ex, em, gx, gm;
        int lat, derr, off;
        logic [21:0] f2;
        do_reset();
        key_i = k; fn_i = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        off = 0;
        if (poke) begin
            repeat (50) @(negedge clk);
            key_i = ~k; fn_i = f ^ 22'h15A5A5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            off = 51;
            chk(!bit_x && !val_x, "R10", {tag, " bit before frame"}, {bit_x, val_x}, 0);
        end
        grab(gx, gm, lat, derr);
        model(k, f, 1'b0, ex);
        model(k, f, 1'b1, em);
        chk(lat + off == 186, "R2", {tag, " first-bit latency"}, lat + off, 186);
        chk(gx == ex, poke ? "R9" : "R5", {tag, " xor frame 1 (R3 R4)"}, gx, ex);
        chk(gm == em, poke ? "R9" : "R6", {tag, " mux frame 1"}, gm, em);
        chk(derr == 0, "R7", {tag, " frame 1 valid/done"}, derr, 0);
        @(negedge clk);
        chk(!val_x && !val_m && !bit_x, "R7", {tag, " valid after done"}, {val_x, val_m, bit_x}, 0);
        grab(gx, gm, lat, derr);
        f2 = f + 22'd1;
        model(k, f2, 1'b0, ex);
        model(k, f2, 1'b1, em);
        chk(lat + 1 == 187, "R8", {tag, " frame gap"}, lat + 1, 187);
        chk(gx == ex, "R8", {tag, " xor frame 2 (R11)"}, gx, ex);
        chk(gm == em, "R11", {tag, " mux frame 2"}, gm, em);
        chk(derr == 0, "R7", {tag, " frame 2 valid/done"}, derr, 0);
    endtask

    task automatic t_reset_midrun();
        do_reset();
        key_i = 64'h0123_4567_89AB_CDEF; fn_i = 22'h00ABC; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (200) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!val_x && !bit_x && !done_x, "R1", "reset during frame", {val_x, bit_x, done_x}, 0);
        rst = 1'b0;
        repeat (250) @(negedge clk);
        chk(!val_x && !val_m, "R1", "stays idle after reset", {val_x, val_m}, 0);
    endtask

    initial begin : wdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_frames(64'h0123_4567_89AB_CDEF, 22'h134, 1'b0, "basic");
        t_frames(64'hFFFF_FFFF_FFFF_FFFF, 22'h0, 1'b0, "ones");
        t_frames(64'h0, 22'h3FFFFF, 1'b0, "wrap");
        t_frames(64'hDEAD_BEEF_0BAD_F00D, 22'h2AAAA, 1'b1, "busy");
        t_reset_midrun();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule